// File: doc/BRIEF.md
# Burst Serial Port with Byte Buffer

This block is one channel of a synchronous serial port. A byte-wide, eight-slot buffer sits behind a serial shift engine. Software fills the buffer, names a burst length and pulses a start strobe. The engine then exchanges one to eight bytes back to back with no further attention. Each byte received from the line replaces the byte that was sent from the same slot. After the burst, software drains the buffer to collect the received bytes. A chip with two serial channels places two instances of this module side by side.

The serial clock can be produced inside the block, which makes the block the master. It can also be taken from the `sck_in` pin, which makes the block a slave. In chip-select mode, the active-low select input decides three things: whether the clock and data outputs are enabled, when bits may move, and whether a burst survives. A select that rises at a byte boundary pauses the burst. A select that rises in the middle of a byte cancels the burst. Tristate control is brought out as enable signals, so the pad ring builds the actual buffers.

Top module: `ssp_burst_port`

## Requirements
- R1: Each accepted `push_en` writes `push_data` into the next slot, counting from slot 0 after reset or after an accepted start. A push is ignored once eight bytes are held, while `busy` is high, or in the cycle of an accepted start.
- R2: A start pulse while idle begins a burst of `burst_len`+1 bytes. `burst_len` is 3 bits, so 0 means one byte and 7 means eight. The burst takes slots 0 upward, and each byte goes out on `sdo` most significant bit first.
- R3: The byte shifted in during each byte time is written back into the slot that byte was sent from. After a start, pops read slots 0 upward. `pop_data` is valid in the cycle after `pop_en` and holds until the next read.
- R4: In master mode, `sck_out` idles high and each phase of it lasts `HALF_DIV` clock cycles, so one serial period is 2*`HALF_DIV`. `sdo` changes together with the falling edge, and `sdi` is sampled on the rising edge.
- R5: In slave mode, the block shifts on the edges of `sck_in`. It presents the next bit after a falling edge and samples `sdi` on a rising edge. `sck_oe` stays low.
- R6: `busy` rises in the cycle after an accepted start. It stays high until the last bit of the last byte has been written back. `done` is a one-cycle pulse in the first cycle `busy` is low again.
- R7: In chip-select mode, `sdo_oe` is low while `cs_n` is high. It goes high within three cycles of `cs_n` falling. `sck_oe` follows it when the block is master. Outside chip-select mode, `sdo_oe` is 1 and `sck_oe` equals `cfg_master`.
- R8: In chip-select mode, no serial clock edge is produced or accepted while `cs_n` is high. A burst started under a high select waits, and no bit moves until the select falls.
- R9: In chip-select mode, if `cs_n` rises after the first falling edge of a byte and before its eighth rising edge, the burst ends. `busy` falls, no `done` pulse occurs, and the partial byte is discarded, so its slot keeps its transmitted value. Bytes already completed keep their received values.
- R10: `start` and `pop_en` have no effect while `busy` is high. A second start during a burst does not change its length, and a pop during a burst does not advance the read position.
- R11: After reset, `busy` and `done` are 0 and `sck_out` and `sdo` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: block generates the serial clock; 0: clock taken from `sck_in` |
| cfg_csmode | input | 1 | 1: chip select gates transfers and output enables |
| push_en | input | 1 | Write `push_data` into the next buffer slot |
| push_data | input | 8 | Byte to store |
| pop_en | input | 1 | Read the next buffer slot |
| pop_data | output | 8 | Byte read, valid the cycle after `pop_en` |
| start | input | 1 | Begin a burst |
| burst_len | input | 3 | Burst length minus one |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when a burst completes |
| sck_in | input | 1 | Serial clock from the line (slave mode) |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| sdi | input | 1 | Serial data from the line |
| sdo | output | 1 | Serial data to the line |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| cs_n | input | 1 | Active-low chip select |

## Verification
The hardest situation to reach from the ports is a select that rises partway through a byte. It must come after a byte has already completed, so that the bench can see both the kept byte and the discarded one. The bench plays the external master in slave chip-select mode and drives the line bit by bit. It sends one whole byte, then only three bits of the next, and then raises the select. It then drains the buffer to confirm that the first slot holds the received byte and that the later slots are unchanged. A master burst started under a high select, with pops and starts issued in the middle of a burst, covers the waiting and ignored-input cases.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDCAP,
    ST_SHIFT,
    ST_WBACK
  } eng_state_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int         W       = 1,
  parameter logic [0:0] RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ssp_byte_ram.sv
module ssp_byte_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // no reset on the array or read register so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ssp_sclk_gen.sv
module ssp_sclk_gen #(
  parameter int HALF_DIV = 80,
  localparam int CW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic run,
  input  logic sck_in_s,
  output logic sck_o,
  output logic fall_evt,
  output logic rise_evt
);
  logic [CW-1:0] cnt;
  logic          sck_q;
  logic          s_prev;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || !master) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (wrap) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s_prev <= 1'b1;
    else     s_prev <= sck_in_s;
  end

  always_comb begin
    if (master) begin
      fall_evt = run && wrap && sck_q;
      rise_evt = run && wrap && !sck_q;
    end else begin
      fall_evt = run && s_prev && !sck_in_s;
      rise_evt = run && !s_prev && sck_in_s;
    end
  end

  assign sck_o = sck_q;

  // R4: generated clock sits high whenever the divider is not running
  a_r4_clock_parks_high: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> sck_o);
endmodule

// File: rtl/ssp_bit_engine.sv
module ssp_bit_engine
  import ssp_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int BCW  = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] burst_len,
  input  logic          cs_mode,
  input  logic          cs_high,
  input  logic          fall_evt,
  input  logic          rise_evt,
  input  logic          sdi_s,
  output logic          run,
  output logic          busy,
  output logic          done,
  output logic          sdo,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [W-1:0]  ram_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [W-1:0]  ram_wdata
);
  eng_state_t     state;
  logic [AW-1:0]  slot;
  logic [AW-1:0]  last;
  logic [W-1:0]   sh;
  logic [BCW-1:0] bits;
  logic           started;
  logic           held;

  assign held      = cs_mode && cs_high;
  assign run       = (state == ST_SHIFT) && !held;
  assign ram_re    = (state == ST_RDREQ);
  assign ram_raddr = slot;
  assign ram_we    = (state == ST_WBACK);
  assign ram_waddr = slot;
  assign ram_wdata = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      slot    <= '0;
      last    <= '0;
      sh      <= '0;
      bits    <= '0;
      started <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sdo     <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            slot  <= '0;
            last  <= burst_len;
            busy  <= 1'b1;
            state <= ST_RDREQ;
          end
        end
        ST_RDREQ: state <= ST_RDCAP;
        ST_RDCAP: begin
          sh      <= ram_rdata;
          bits    <= '0;
          started <= 1'b0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (held && started) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            if (fall_evt) begin
              sdo     <= sh[W-1];
              started <= 1'b1;
            end
            if (rise_evt) begin
              sh   <= {sh[W-2:0], sdi_s};
              bits <= bits + 1'b1;
              if (bits == BCW'(W - 1)) state <= ST_WBACK;
            end
          end
        end
        ST_WBACK: begin
          if (slot == last) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            slot  <= slot + 1'b1;
            state <= ST_RDREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4 / R8: serial edges reach the engine only while it is shifting
  a_r8_edges_only_when_shifting: assert property (@(posedge clk) disable iff (rst)
    (fall_evt || rise_evt) |-> (state == ST_SHIFT));
  // R6: an accepted start raises busy on the next cycle
  a_r6_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R6: completion pulse only as busy falls
  a_r6_done_as_busy_falls: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R10: slot index never passes the burst end
  a_r10_slot_within_burst: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot <= last));
endmodule

// File: rtl/ssp_burst_port.sv
module ssp_burst_port #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int HALF_DIV = 80,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_csmode,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  input  logic              start,
  input  logic [AW-1:0]     burst_len,
  output logic              busy,
  output logic              done,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              cs_n
);
  logic              cs_s, sck_s, sdi_s;
  logic              run, fall_evt, rise_evt;
  logic              eng_re, eng_we;
  logic [AW-1:0]     eng_raddr, eng_waddr;
  logic [DATA_W-1:0] eng_wdata, ram_rdata;
  logic [CW-1:0]     wr_cnt;
  logic [AW-1:0]     rd_ptr;
  logic              start_ok, push_ok, pop_ok, cs_ok;

  ssp_sync #(.W(2), .RST_VAL(1'b1)) u_sync_hi (
    .clk(clk), .rst(rst), .d({cs_n, sck_in}), .q({cs_s, sck_s}));
  ssp_sync #(.W(1), .RST_VAL(1'b0)) u_sync_lo (
    .clk(clk), .rst(rst), .d(sdi), .q(sdi_s));

  assign start_ok = start && !busy;
  assign push_ok  = push_en && !busy && !start_ok && (wr_cnt < CW'(DEPTH));
  assign pop_ok   = pop_en && !busy && !start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else if (start_ok) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_cnt <= wr_cnt + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  ssp_byte_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (eng_we || push_ok),
    .waddr(eng_we ? eng_waddr : wr_cnt[AW-1:0]),
    .wdata(eng_we ? eng_wdata : push_data),
    .re   (eng_re || pop_ok),
    .raddr(eng_re ? eng_raddr : rd_ptr),
    .rdata(ram_rdata)
  );

  ssp_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .master(cfg_master), .run(run), .sck_in_s(sck_s),
    .sck_o(sck_out), .fall_evt(fall_evt), .rise_evt(rise_evt));

  ssp_bit_engine #(.W(DATA_W), .DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst(rst), .start(start_ok), .burst_len(burst_len),
    .cs_mode(cfg_csmode), .cs_high(cs_s), .fall_evt(fall_evt),
    .rise_evt(rise_evt), .sdi_s(sdi_s), .run(run), .busy(busy), .done(done),
    .sdo(sdo), .ram_re(eng_re), .ram_raddr(eng_raddr), .ram_rdata(ram_rdata),
    .ram_we(eng_we), .ram_waddr(eng_waddr), .ram_wdata(eng_wdata));

  assign pop_data = ram_rdata;
  assign cs_ok    = !cfg_csmode || !cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe <= 1'b0;
      sck_oe <= 1'b0;
    end else begin
      sdo_oe <= cs_ok;
      sck_oe <= cfg_master && cs_ok;
    end
  end

  // R1: fill level never exceeds the buffer depth
  a_r1_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= CW'(DEPTH));
  // R4: outside a burst the clock pin rests high
  a_r4_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck_out);
  // R3: buffer write port never claimed by software and engine at once
  a_r3_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(eng_we && push_ok));
endmodule

// File: tb/ssp_burst_port_tb.sv
module ssp_burst_port_tb;
  localparam int HALF = 4;
  localparam int SH   = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cfg_master = 1'b1, cfg_csmode = 1'b0;
  logic       push_en = 1'b0, pop_en = 1'b0, start = 1'b0;
  logic [7:0] push_data = '0, pop_data;
  logic [2:0] burst_len = '0;
  logic       busy, done, sck_out, sck_oe, sdo, sdo_oe;
  logic       sck_in = 1'b1, cs_n = 1'b1;
  logic       sdi, sdi_peer = 1'b0, sdi_slv = 1'b0, slave_mode = 1'b0;

  assign sdi = slave_mode ? sdi_slv : sdi_peer;
  always #4 clk = ~clk;

  ssp_burst_port #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_csmode(cfg_csmode),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .pop_data(pop_data), .start(start), .burst_len(burst_len), .busy(busy),
    .done(done), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cs_n(cs_n));

  int nvec = 0, nerr = 0, n_done = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] peer_tx [8];
  logic [7:0] cap [8];
  logic [7:0] tx [8];
  bit peer_on = 0;
  int pbit = 0, nfall = 0, last_fall = 0, per0 = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && done) n_done <= n_done + 1;
  end

  always @(negedge sck_out) if (peer_on) begin
    if (nfall == 1) per0 = cyc - last_fall;
    last_fall = cyc;
    nfall++;
    sdi_peer <= peer_tx[(pbit / 8) % 8][7 - (pbit % 8)];
  end

  always @(posedge sck_out) if (peer_on) begin
    cap[(pbit / 8) % 8][7 - (pbit % 8)] = sdo;
    pbit++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); push_en = 1'b1; push_data = b;
    @(negedge clk); push_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); pop_en = 1'b1;
    @(negedge clk); pop_en = 1'b0; b = pop_data;
  endtask

  task automatic kick(logic [2:0] len);
    @(negedge clk); start = 1'b1; burst_len = len;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk("R6 burst finishes", {31'd0, busy}, 32'd0);
  endtask

  task automatic master_burst(int len, bit csm, bit meddle);
    logic [7:0] b;
    int d0;
    cfg_master = 1'b1; cfg_csmode = csm; slave_mode = 1'b0;
    for (int k = 0; k < 8; k++) begin peer_tx[k] = 8'($urandom); tx[k] = 8'($urandom); end
    for (int k = 0; k <= len; k++) push(tx[k]);
    cs_n = csm ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    pbit = 0; nfall = 0; peer_on = 1; d0 = n_done;
    kick(3'(len));
    if (meddle) begin
      repeat (6) @(negedge clk);
      kick(3'(7 - len));
      @(negedge clk); pop_en = 1'b1; @(negedge clk); pop_en = 1'b0;
    end
    wait_idle();
    repeat (2) @(negedge clk);
    peer_on = 0;
    chk("R2 bits exchanged", pbit, (len + 1) * 8);
    chk("R6 one done pulse", n_done - d0, 1);
    if (len > 0) chk("R4 serial period", per0, 2 * HALF);
    for (int k = 0; k <= len; k++) chk("R2 byte sent MSB first", cap[k], tx[k]);
    for (int k = 0; k <= len; k++) begin
      pop(b);
      chk(meddle ? "R10 pop ignored while busy" : "R3 received byte in slot", b, peer_tx[k]);
    end
    cs_n = 1'b1;
  endtask

  task automatic slave_bits(logic [7:0] txb, output logic [7:0] rxb, input int nb);
    rxb = '0;
    for (int i = 0; i < nb; i++) begin
      sck_in = 1'b0; sdi_slv = txb[7 - i];
      repeat (SH) @(negedge clk);
      rxb[7 - i] = sdo;
      sck_in = 1'b1;
      repeat (SH) @(negedge clk);
    end
  endtask

  task automatic slave_burst(int len, bit csm);
    logic [7:0] b;
    int d0;
    cfg_master = 1'b0; cfg_csmode = csm; slave_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin peer_tx[k] = 8'($urandom); tx[k] = 8'($urandom); end
    for (int k = 0; k <= len; k++) push(tx[k]);
    cs_n = csm ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    d0 = n_done;
    kick(3'(len));
    repeat (4) @(negedge clk);
    chk("R5 no clock drive as slave", {31'd0, sck_oe}, 32'd0);
    for (int k = 0; k <= len; k++) begin
      slave_bits(peer_tx[k], b, 8);
      chk("R5 slave byte out", b, tx[k]);
    end
    repeat (6) @(negedge clk);
    chk("R6 busy low after last bit", {31'd0, busy}, 32'd0);
    chk("R6 one done pulse", n_done - d0, 1);
    for (int k = 0; k <= len; k++) begin
      pop(b);
      chk("R3 slave received byte in slot", b, peer_tx[k]);
    end
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, rx0;
    int d0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", {31'd0, busy}, 32'd0);
    chk("R11 done after reset", {31'd0, done}, 32'd0);
    chk("R11 sck idle high", {31'd0, sck_out}, 32'd1);
    chk("R11 sdo idle high", {31'd0, sdo}, 32'd1);
    chk("R7 sdo_oe outside cs mode", {31'd0, sdo_oe}, 32'd1);
    chk("R7 sck_oe as master", {31'd0, sck_oe}, 32'd1);

    // R1: ninth push ignored, eight-byte burst
    cfg_master = 1'b1; slave_mode = 1'b0;
    for (int k = 0; k < 8; k++) begin tx[k] = 8'($urandom); peer_tx[k] = 8'($urandom); end
    for (int k = 0; k < 8; k++) push(tx[k]);
    push(8'hA5);
    pbit = 0; nfall = 0; peer_on = 1;
    kick(3'd7);
    wait_idle();
    repeat (2) @(negedge clk);
    peer_on = 0;
    for (int k = 0; k < 8; k++) chk("R1 slots hold first eight pushes", cap[k], tx[k]);
    for (int k = 0; k < 8; k++) begin pop(b); chk("R3 full burst readback", b, peer_tx[k]); end

    // R10: second start and pop during a burst are ignored
    master_burst(2, 1'b0, 1'b1);

    // R7 / R8: master burst under a high select waits
    cfg_csmode = 1'b1; cs_n = 1'b1;
    tx[0] = 8'h3C; peer_tx[0] = 8'hC3;
    push(tx[0]);
    repeat (4) @(negedge clk);
    chk("R7 sdo floats with cs high", {31'd0, sdo_oe}, 32'd0);
    chk("R7 sck floats with cs high", {31'd0, sck_oe}, 32'd0);
    pbit = 0; nfall = 0; peer_on = 1; d0 = n_done;
    kick(3'd0);
    repeat (60) @(negedge clk);
    chk("R8 no clock while cs high", nfall, 0);
    chk("R8 burst still pending", {31'd0, busy}, 32'd1);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 sdo driven after cs low", {31'd0, sdo_oe}, 32'd1);
    chk("R7 sck driven after cs low", {31'd0, sck_oe}, 32'd1);
    wait_idle();
    repeat (2) @(negedge clk);
    peer_on = 0;
    chk("R8 byte sent after cs low", cap[0], 8'h3C);
    chk("R6 done after waited burst", n_done - d0, 1);
    pop(b); chk("R3 waited burst readback", b, 8'hC3);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 sdo floats after cs rises", {31'd0, sdo_oe}, 32'd0);

    // R9: select rises mid-byte in slave chip-select mode
    cfg_master = 1'b0; cfg_csmode = 1'b1; slave_mode = 1'b1;
    push(8'h81); push(8'h42); push(8'h24);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    d0 = n_done;
    kick(3'd2);
    repeat (4) @(negedge clk);
    slave_bits(8'h5A, rx0, 8);
    chk("R9 first byte out", rx0, 8'h81);
    slave_bits(8'hFF, b, 3);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 busy drops on abort", {31'd0, busy}, 32'd0);
    chk("R9 no done on abort", n_done - d0, 0);
    pop(b); chk("R9 completed byte kept", b, 8'h5A);
    pop(b); chk("R9 partial byte discarded", b, 8'h42);
    pop(b); chk("R9 untouched slot", b, 8'h24);

    // random mix of modes and lengths
    for (int it = 0; it < 16; it++) begin
      int len;
      bit csm;
      len = int'($urandom_range(0, 7));
      csm = 1'($urandom);
      if ($urandom_range(0, 1) == 1) master_burst(len, csm, 1'b0);
      else                           slave_burst(len, csm);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule